// File: doc/BRIEF.md
# Store-Merging Line Fill Buffer

This block is a small set of cache-line entries that sits between a load/store pipeline and an L1 data cache. Two kinds of traffic claim entries: cacheable stores from the store path, and load misses waiting for their line to return from the bus. A store is always taken into an entry, whether or not its line is cached, so the store queue slot it came from can be released in the same cycle. Stores to a line that already has an entry merge into that entry, and never open a second one.

Fill beats arrive one double word at a time, critical beat first, and are written only into bytes that no store has claimed. Newer store data therefore always wins over older memory data. A load that names a line held in the buffer reads its bytes directly from the entry, including bytes that a buffered store wrote. If any requested byte is still missing, the load instead gets a pending status.

When every byte of an entry is valid, the buffer offers the whole line to the cache over a valid/ready pair. The entry is freed on the beat the cache accepts.

Top module: `lfb_merge`

## Requirements
- R1: A store (`st_valid`) is accepted when its line matches a held entry or when some entry is free. A store to an unheld line is allocated a free entry, with only the stored bytes marked valid.
- R2: Once a store is accepted, its line is held by an entry from the next cycle on, until that line is written to the cache.
- R3: A load hits when its line is held and every byte selected by `ld_be` is valid in that entry. `ld_data` then returns those bytes. Address bits [4:3] select the double word. Bit k of `ld_be`, `st_be` or a beat covers data bits 8k+7:8k, which is line byte 8*beat+k.
- R4: No two entries ever hold the same line. Stores to a held line merge into its entry.
- R5: A load to a held line with any selected byte not yet valid raises `ld_pend` and not `ld_hit`. A load to an unheld line raises neither.
- R6: With no matching entry and no free entry, `st_ready` and `miss_ready` stay low. When a store and a miss both need a new entry in one cycle, the store takes it and the miss waits.
- R7: `wr_valid` is high whenever some entry is complete, offering the lowest-numbered complete entry. `wr_addr` is line aligned (low 5 bits zero) and byte b of `wr_data` sits at bits 8b+7:8b. An offer not accepted stays valid. The entry is freed on the cycle `wr_ready` is high.
- R8: A fill beat writes only bytes not already valid in the entry holding its line, so store bytes win over fill bytes. A fill whose line is not held has no effect.
- R9: A store whose matching entry is being written to the cache in that cycle is held off (`st_ready` low).
- R10: A miss to an unheld line allocates an entry with no valid bytes. A miss to a held line is accepted without allocating.
- R11: After reset no entry is held, `wr_valid` is low, and stores are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Store byte address (double word aligned) |
| st_be | input | 8 | Store byte enables |
| st_data | input | 64 | Store data |
| miss_valid | input | 1 | Load-miss allocation request |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_addr | input | 32 | Missing line address |
| fill_valid | input | 1 | Fill beat present |
| fill_addr | input | 32 | Fill beat address (line and double word) |
| fill_data | input | 64 | Fill beat data |
| ld_valid | input | 1 | Load lookup |
| ld_addr | input | 32 | Load address (double word aligned) |
| ld_be | input | 8 | Bytes the load needs |
| ld_hit | output | 1 | All needed bytes forwarded |
| ld_pend | output | 1 | Line held but bytes missing |
| ld_data | output | 64 | Forwarded double word |
| wr_valid | output | 1 | Complete line offered to cache |
| wr_ready | input | 1 | Cache takes the line |
| wr_addr | output | 32 | Line address of the offer |
| wr_data | output | 256 | Full line data |

## Verification
On every cycle the assertions check four things: that no line is held twice, that an accepted store's line is present on the following cycle, that a refused store happens only when the buffer is full or a line is on offer, and that an unaccepted cache offer persists. Load hit and pending status are also checked never to coincide. Store-over-fill byte priority, the exact forwarded bytes, the lowest-index offer order, and the stall of a store against a retiring entry are only visible through the bench. There a behavioural model of the entries is compared against every output on every cycle. The traffic runs over a handful of lines, and the cache readiness is starved in one phase so that the full-buffer stall is reached.

// File: rtl/lfb_merge.sv
module lfb_merge #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [BEAT_BYTES-1:0]   st_be,
  input  logic [BEAT_BYTES*8-1:0] st_data,
  input  logic                    miss_valid,
  output logic                    miss_ready,
  input  logic [ADDR_W-1:0]       miss_addr,
  input  logic                    fill_valid,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [BEAT_BYTES*8-1:0] fill_data,
  input  logic                    ld_valid,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [BEAT_BYTES-1:0]   ld_be,
  output logic                    ld_hit,
  output logic                    ld_pend,
  output logic [BEAT_BYTES*8-1:0] ld_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LINE_BYTES*8-1:0] wr_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(BEAT_BYTES);
  localparam int BI_W   = OFF_W - BOFF_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int BEAT_W = BEAT_BYTES * 8;

  logic [ENTRIES-1:0]      busy_q;
  logic [TAG_W-1:0]        tag_q  [ENTRIES];
  logic [LINE_BYTES-1:0]   bv_q   [ENTRIES];
  logic [LINE_BYTES*8-1:0] data_q [ENTRIES];

  wire [TAG_W-1:0] st_tag = st_addr[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] mi_tag = miss_addr[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] fl_tag = fill_addr[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] ld_tag = ld_addr[ADDR_W-1:OFF_W];
  wire [BI_W-1:0]  st_bi  = st_addr[OFF_W-1:BOFF_W];
  wire [BI_W-1:0]  fl_bi  = fill_addr[OFF_W-1:BOFF_W];
  wire [BI_W-1:0]  ld_bi  = ld_addr[OFF_W-1:BOFF_W];

  logic [ENTRIES-1:0] st_m, mi_m, fl_m, ld_m, full;
  logic [IDX_W-1:0]   st_idx, ld_idx, free_idx, wr_idx;
  logic               any_free;

  always_comb begin
    st_idx = '0; ld_idx = '0; free_idx = '0; wr_idx = '0;
    any_free = 1'b0; wr_valid = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      st_m[i] = busy_q[i] && tag_q[i] == st_tag;
      mi_m[i] = busy_q[i] && tag_q[i] == mi_tag;
      fl_m[i] = busy_q[i] && tag_q[i] == fl_tag;
      ld_m[i] = busy_q[i] && tag_q[i] == ld_tag;
      full[i] = busy_q[i] && &bv_q[i];
      if (st_m[i]) st_idx = IDX_W'(i);
      if (ld_m[i]) ld_idx = IDX_W'(i);
      if (!busy_q[i]) begin free_idx = IDX_W'(i); any_free = 1'b1; end
      if (full[i]) begin wr_idx = IDX_W'(i); wr_valid = 1'b1; end
    end
  end

  wire wr_fire  = wr_valid && wr_ready;
  wire st_blk   = wr_fire && wr_idx == st_idx;
  assign st_ready   = (|st_m) ? !st_blk : any_free;
  wire st_alloc = st_valid && !(|st_m) && any_free;
  wire st_do    = st_valid && st_ready;
  assign miss_ready = (|mi_m) || (any_free && !st_alloc);
  wire mi_alloc = miss_valid && !(|mi_m) && any_free && !st_alloc;

  wire [BEAT_BYTES-1:0] ld_bv = bv_q[ld_idx][ld_bi*BEAT_BYTES +: BEAT_BYTES];
  wire ld_all = &(ld_bv | ~ld_be);
  assign ld_hit  = ld_valid && (|ld_m) && ld_all;
  assign ld_pend = ld_valid && (|ld_m) && !ld_all;
  assign ld_data = data_q[ld_idx][ld_bi*BEAT_W +: BEAT_W];
  assign wr_addr = {tag_q[wr_idx], {OFF_W{1'b0}}};
  assign wr_data = data_q[wr_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[i] <= 1'b0;
        bv_q[i]   <= '0;
      end else if (wr_fire && wr_idx == IDX_W'(i)) begin
        busy_q[i] <= 1'b0;
        bv_q[i]   <= '0;
      end else if (st_alloc && free_idx == IDX_W'(i)) begin
        busy_q[i] <= 1'b1;
        tag_q[i]  <= st_tag;
        for (int b = 0; b < LINE_BYTES; b++) begin
          bv_q[i][b]         <= st_bi == BI_W'(b / BEAT_BYTES) && st_be[b % BEAT_BYTES];
          data_q[i][b*8 +: 8] <= st_data[(b % BEAT_BYTES)*8 +: 8];
        end
      end else if (mi_alloc && free_idx == IDX_W'(i)) begin
        busy_q[i] <= 1'b1;
        tag_q[i]  <= mi_tag;
        bv_q[i]   <= '0;
      end else begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (st_do && st_m[i] && st_bi == BI_W'(b / BEAT_BYTES) && st_be[b % BEAT_BYTES]) begin
            bv_q[i][b]          <= 1'b1;
            data_q[i][b*8 +: 8] <= st_data[(b % BEAT_BYTES)*8 +: 8];
          end else if (fill_valid && fl_m[i] && fl_bi == BI_W'(b / BEAT_BYTES) && !bv_q[i][b]) begin
            bv_q[i][b]          <= 1'b1;
            data_q[i][b*8 +: 8] <= fill_data[(b % BEAT_BYTES)*8 +: 8];
          end
        end
      end
    end
  end
endmodule

// File: rtl/lfb_merge_chk.sv
module lfb_merge_chk #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic [ADDR_W-1:0]  st_addr,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               ld_hit,
  input logic               ld_pend,
  input logic [ENTRIES-1:0] busy_q,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] tag_q [ENTRIES]
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] last_tag_q;
  logic dup, present;

  always_ff @(posedge clk) last_tag_q <= st_addr[ADDR_W-1:OFF_W];

  always_comb begin
    dup = 1'b0;
    present = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (busy_q[i] && tag_q[i] == last_tag_q) present = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++)
        if (busy_q[i] && busy_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
    end
  end

  p_unique_line_r4: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  p_store_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> present);
  p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> (&busy_q) || wr_valid);
  p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);
  p_hit_xor_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_hit, ld_pend}));
endmodule

bind lfb_merge lfb_merge_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .ld_hit(ld_hit), .ld_pend(ld_pend),
  .busy_q(busy_q), .tag_q(tag_q)
);

// File: tb/tb_lfb_merge.sv
module tb_lfb_merge;
  localparam int NE = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, st_valid, miss_valid, fill_valid, ld_valid, wr_ready;
  logic st_ready, miss_ready, ld_hit, ld_pend, wr_valid;
  logic [31:0] st_addr, miss_addr, fill_addr, ld_addr, wr_addr;
  logic [7:0] st_be, ld_be;
  logic [63:0] st_data, fill_data, ld_data;
  logic [255:0] wr_data;

  lfb_merge dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be), .ld_hit(ld_hit), .ld_pend(ld_pend),
    .ld_data(ld_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  bit          m_busy [NE];
  bit [26:0]   m_tag  [NE];
  bit          m_bv   [NE][32];
  bit [7:0]    m_d    [NE][32];

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find(bit [26:0] t);
    for (int i = 0; i < NE; i++) if (m_busy[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic step();
    int sm, mm, fm, lm, fr, fu;
    bit fire, salloc, e_sr, e_mr, e_hit, e_pend, allv;
    int sbi, fbi, lbi;
    logic [255:0] e_line;
    logic [63:0] e_ld, mask;
    sm = find(st_addr[31:5]); mm = find(miss_addr[31:5]);
    fm = find(fill_addr[31:5]); lm = find(ld_addr[31:5]);
    sbi = int'(st_addr[4:3]); fbi = int'(fill_addr[4:3]); lbi = int'(ld_addr[4:3]);
    fr = -1; fu = -1;
    for (int i = 0; i < NE; i++) begin
      if (!m_busy[i]) begin
        if (fr < 0) fr = i;
      end else if (fu < 0) begin
        bit all1;
        all1 = 1;
        for (int b = 0; b < 32; b++) if (!m_bv[i][b]) all1 = 0;
        if (all1) fu = i;
      end
    end
    fire   = fu >= 0 && wr_ready;
    e_sr   = sm >= 0 ? !(fire && sm == fu) : fr >= 0;
    salloc = st_valid && sm < 0 && fr >= 0;
    e_mr   = mm >= 0 || (fr >= 0 && !salloc);
    allv = 1;
    if (lm >= 0) for (int k = 0; k < 8; k++) if (ld_be[k] && !m_bv[lm][lbi*8+k]) allv = 0;
    e_hit  = ld_valid && lm >= 0 && allv;
    e_pend = ld_valid && lm >= 0 && !allv;

    chk("R1/R6/R9 st_ready", 256'(st_ready), 256'(e_sr));
    chk("R6/R10 miss_ready", 256'(miss_ready), 256'(e_mr));
    chk("R3/R5 ld_hit", 256'(ld_hit), 256'(e_hit));
    chk("R5 ld_pend", 256'(ld_pend), 256'(e_pend));
    chk("R7 wr_valid", 256'(wr_valid), 256'(fu >= 0));
    if (fu >= 0) begin
      for (int b = 0; b < 32; b++) e_line[b*8 +: 8] = m_d[fu][b];
      chk("R4/R7 wr_addr", 256'(wr_addr), 256'({m_tag[fu], 5'd0}));
      chk("R7/R8 wr_data", wr_data, e_line);
    end
    if (e_hit) begin
      for (int k = 0; k < 8; k++) begin
        e_ld[k*8 +: 8] = m_d[lm][lbi*8+k];
        mask[k*8 +: 8] = {8{ld_be[k]}};
      end
      chk("R2/R3 ld_data", 256'(ld_data & mask), 256'(e_ld & mask));
    end

    if (fire) begin
      m_busy[fu] = 0;
      for (int b = 0; b < 32; b++) m_bv[fu][b] = 0;
    end
    if (st_valid && e_sr) begin
      int t;
      t = sm >= 0 ? sm : fr;
      if (sm < 0) begin
        m_busy[t] = 1; m_tag[t] = st_addr[31:5];
        for (int b = 0; b < 32; b++) m_bv[t][b] = 0;
      end
      for (int k = 0; k < 8; k++) if (st_be[k]) begin
        m_bv[t][sbi*8+k] = 1; m_d[t][sbi*8+k] = st_data[k*8 +: 8];
      end
    end
    if (miss_valid && e_mr && mm < 0) begin
      m_busy[fr] = 1; m_tag[fr] = miss_addr[31:5];
      for (int b = 0; b < 32; b++) m_bv[fr][b] = 0;
    end
    if (fill_valid && fm >= 0 && !(fire && fm == fu)) begin
      for (int k = 0; k < 8; k++) if (!m_bv[fm][fbi*8+k]) begin
        m_bv[fm][fbi*8+k] = 1; m_d[fm][fbi*8+k] = fill_data[k*8 +: 8];
      end
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    return {27'h100 + 27'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), 3'd0};
  endfunction

  initial begin
    rst_n = 0; st_valid = 0; miss_valid = 0; fill_valid = 0; ld_valid = 0; wr_ready = 0;
    st_addr = 0; miss_addr = 0; fill_addr = 0; ld_addr = 0; st_be = 0; ld_be = 0;
    st_data = 0; fill_data = 0;
    for (int i = 0; i < NE; i++) m_busy[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 wr_valid after reset", 256'(wr_valid), 256'(0));
    chk("R11 st_ready after reset", 256'(st_ready), 256'(1));
    rst_n = 1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int rdy_pct;
      @(negedge clk);
      rdy_pct = (cyc >= 2000 && cyc < 3000) ? 3 : 70;
      st_valid   = $urandom_range(0, 99) < 40;
      st_addr    = rnd_addr();
      st_be      = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(1, 255));
      st_data    = {$urandom, $urandom};
      miss_valid = $urandom_range(0, 99) < 25;
      miss_addr  = rnd_addr();
      fill_valid = $urandom_range(0, 99) < 50;
      fill_addr  = rnd_addr();
      fill_data  = {$urandom, $urandom};
      ld_valid   = $urandom_range(0, 99) < 60;
      ld_addr    = rnd_addr();
      ld_be      = 8'($urandom_range(1, 255));
      wr_ready   = $urandom_range(0, 99) < rdy_pct;
      #1;
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule